// File: doc/BRIEF.md
# Two-Input Up/Down and Quadrature Event Timer

This block is a 16-bit event counter driven by two asynchronous pins: an event clock and a direction level. Both pins pass through a two-flop synchronizer. In direction mode every change of the event clock, rising or falling, moves the count by one step. The direction level chooses whether that step goes up or down. In quadrature mode the two pins are read as the A and B phases of an incremental encoder. Each single-phase change moves the count by one, and the phase order sets the direction.

The count wraps at both ends. A one-cycle strobe marks each wrap: overflow for an up step from all ones, and underflow for a down step from zero. A synchronous load writes any value and takes priority over a step in the same cycle. When the block is disabled the count holds. The pin history still tracks the pins, so turning counting back on does not produce a false step.

Top module: `qtm_timer`

## Requirements
- R1: During and after reset, with both pins low, count_o is 0 and ovf_o and unf_o are 0.
- R2: In direction mode (quad_mode_i = 0), every rising edge and every falling edge of evt_clk_i changes the count by exactly one. A change of evt_dir_i alone does not change the count.
- R3: In direction mode, a step goes up when the synchronized evt_dir_i is 1 and down when it is 0. The direction value used is the one sampled together with the clock edge.
- R4: In quadrature mode (quad_mode_i = 1), A = evt_clk_i and B = evt_dir_i. The transitions {A,B} 00→10, 10→11, 11→01 and 01→00 each count up by one. The reverse transitions each count down by one.
- R5: In quadrature mode, a sample in which A and B both change leaves the count unchanged.
- R6: An up step from 16'hFFFF gives 16'h0000, and ovf_o is 1 in the same cycle as the new count and for that cycle only.
- R7: A down step from 16'h0000 gives 16'hFFFF, and unf_o is 1 in the same cycle as the new count and for that cycle only.
- R8: When load_i is 1 at a clock edge, count_o equals load_val_i after that edge. This holds even if a step is due at the same edge. A load never raises ovf_o or unf_o.
- R9: While enable_i is 0 the count holds, whatever the pins do. Pin changes made while disabled cause no step after enable_i returns to 1.
- R10: A pin change driven just after clock edge N shows on count_o after edge N+3 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_clk_i | input | 1 | Asynchronous event clock pin (phase A in quadrature mode) |
| evt_dir_i | input | 1 | Asynchronous direction pin (phase B in quadrature mode) |
| quad_mode_i | input | 1 | 0 = clock plus direction, 1 = quadrature decode |
| enable_i | input | 1 | Counting enable |
| load_i | input | 1 | Synchronous load strobe |
| load_val_i | input | 16 | Value written by a load |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle strobe on an up wrap |
| unf_o | output | 1 | One-cycle strobe on a down wrap |

## Verification
In direction mode the clock pin is toggled over a run of edges while the direction level changes between edges. This separates counting on both edges from counting on a single edge, and shows that a direction change alone is not counted. In quadrature mode all sixteen pairs of previous and next {A,B} states are applied. This covers the forward steps, the reverse steps, the unchanged pairs and the double changes, and each outcome is computed from the phase rule. Loads near both ends of the range exercise the wraps and the strobe timing. A load timed to land in the same cycle as a pending step tests load priority. Toggling the pins while the block is disabled, then re-enabling it, tests that no false step appears.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
    typedef enum logic {
        MODE_DIRCLK = 1'b0,
        MODE_QUAD   = 1'b1
    } qtm_mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } qtm_pair_t;
endpackage

// File: rtl/qtm_sync.sv
module qtm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

    // R10: the output only takes values that were one stage behind it a cycle earlier
    generate
        if (STAGES > 1) begin : g_chk
            assert_sync_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
                sync_o == $past(stage_q[STAGES-2]));
        end
    endgenerate
endmodule

// File: rtl/qtm_step_decode.sv
module qtm_step_decode
    import qtm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_i,
    input  logic      b_i,
    input  qtm_mode_e mode_i,
    input  logic      enable_i,
    output logic      step_o,
    output logic      up_o
);
    qtm_pair_t hist_q, hist_d;
    logic chg_a, chg_b, raw_step, raw_up;

    always_comb begin
        hist_d   = '{a: a_i, b: b_i};
        chg_a    = a_i ^ hist_q.a;
        chg_b    = b_i ^ hist_q.b;
        raw_step = 1'b0;
        raw_up   = 1'b0;
        case (mode_i)
            MODE_DIRCLK: begin
                raw_step = chg_a;
                raw_up   = b_i;
            end
            MODE_QUAD: begin
                raw_step = chg_a ^ chg_b;
                raw_up   = a_i ^ hist_q.b;
            end
            default: ;
        endcase
        step_o = raw_step & enable_i;
        up_o   = raw_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // R9: no step leaves the decoder while counting is off
    assert_no_step_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !step_o);
    // R5: a double phase change in quadrature mode is dropped
    assert_quad_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_QUAD && a_i != hist_q.a && b_i != hist_q.b) |-> !step_o);
    // R2: with a steady clock pin, direction mode produces no step
    assert_dir_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DIRCLK && a_i == hist_q.a) |-> !step_o);
endmodule

// File: rtl/qtm_counter.sv
module qtm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             up_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             ovf;
        logic             unf;
    } cnt_state_t;

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (load_i) begin
            st_d.count = load_val_i;
        end else if (step_i) begin
            if (up_i) begin
                st_d.count = st_q.count + CNT_ONE;
                st_d.ovf   = (st_q.count == CNT_MAX);
            end else begin
                st_d.count = st_q.count - CNT_ONE;
                st_d.unf   = (st_q.count == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign ovf_o   = st_q.ovf;
    assign unf_o   = st_q.unf;

    assert_ovf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0 && !unf_o));
    assert_ovf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);
    assert_unf_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (count_o == CNT_MAX && !ovf_o));
    assert_unf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> !unf_o);
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i) && !ovf_o && !unf_o));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(count_o) && !ovf_o && !unf_o));
endmodule

// File: rtl/qtm_timer.sv
module qtm_timer
    import qtm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_clk_i,
    input  logic             evt_dir_i,
    input  logic             quad_mode_i,
    input  logic             enable_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int PIN_W = 2;

    logic [PIN_W-1:0] pins_sync;
    logic             step, up;
    qtm_mode_e        mode;

    assign mode = qtm_mode_e'(quad_mode_i);

    qtm_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({evt_clk_i, evt_dir_i}),
        .sync_o  (pins_sync)
    );

    qtm_step_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_i      (pins_sync[1]),
        .b_i      (pins_sync[0]),
        .mode_i   (mode),
        .enable_i (enable_i),
        .step_o   (step),
        .up_o     (up)
    );

    qtm_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .up_i       (up),
        .load_i     (load_i),
        .load_val_i (load_val_i),
        .count_o    (count_o),
        .ovf_o      (ovf_o),
        .unf_o      (unf_o)
    );
endmodule

// File: tb/qtm_timer_test.sv
module qtm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_clk_i = 1'b0, evt_dir_i = 1'b0;
    logic        quad_mode_i = 1'b0, enable_i = 1'b1, load_i = 1'b0;
    logic [15:0] load_val_i = '0;
    logic [15:0] count_o;
    logic        ovf_o, unf_o;

    int n_checks = 0, n_fail = 0;
    logic [15:0] exp_cnt = '0;
    logic cur_a = 1'b0, cur_b = 1'b0;

    always #2.5 clk = ~clk;

    qtm_timer uut (
        .clk(clk), .rst_n(rst_n), .evt_clk_i(evt_clk_i), .evt_dir_i(evt_dir_i),
        .quad_mode_i(quad_mode_i), .enable_i(enable_i), .load_i(load_i),
        .load_val_i(load_val_i), .count_o(count_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // signed step expected from the requirements for one pin change
    function automatic int delta(input logic q, input logic pa, input logic pb,
                                 input logic a, input logic b);
        if (!q) return (a != pa) ? (b ? 1 : -1) : 0;
        if ((a != pa) == (b != pb)) return 0;
        return (a ^ pb) ? 1 : -1;
    endfunction

    // drive a pin pair just after an edge, then check R10 timing and the result
    task automatic move(input logic na, input logic nb, input string req);
        int d;
        logic [15:0] old;
        d = enable_i ? delta(quad_mode_i, cur_a, cur_b, na, nb) : 0;
        old = exp_cnt;
        evt_clk_i = na; evt_dir_i = nb;
        @(negedge clk); @(negedge clk);
        check(count_o == old, "R10", count_o, old);
        @(negedge clk);
        exp_cnt = old + 16'(d);
        check(count_o == exp_cnt, req, count_o, exp_cnt);
        check(ovf_o == (d == 1 && old == 16'hFFFF), "R6", ovf_o, (d == 1 && old == 16'hFFFF));
        check(unf_o == (d == -1 && old == 16'h0000), "R7", unf_o, (d == -1 && old == 16'h0000));
        cur_a = na; cur_b = nb;
    endtask

    task automatic do_load(input logic [15:0] v);
        load_i = 1'b1; load_val_i = v;
        @(negedge clk);
        load_i = 1'b0;
        exp_cnt = v;
        check(count_o == v && !ovf_o && !unf_o, "R8", count_o, v);
    endtask

    initial begin
        #500us;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check(count_o == 0 && !ovf_o && !unf_o, "R1", count_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(count_o == 0 && !ovf_o && !unf_o, "R1", count_o, 0);

        // R2/R3: direction mode sweep, direction changed between edges
        for (int i = 0; i < 24; i++) begin
            logic nd;
            nd = ((i % 7) < 4);
            if (nd != cur_b) move(cur_a, nd, "R2");
            move(~cur_a, cur_b, "R3");
        end
        // clock edge and direction change in the same sample (R3)
        move(~cur_a, ~cur_b, "R3");
        move(~cur_a, ~cur_b, "R3");

        // R4/R5: every previous/next pair in quadrature mode
        quad_mode_i = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic pa, pb, na, nb;
                pa = p[1]; pb = p[0]; na = n[1]; nb = n[0];
                if (pa != cur_a || pb != cur_b) begin
                    if (pa != cur_a && pb != cur_b) move(pa, cur_b, "R4");
                    move(pa, pb, "R4");
                end
                move(na, nb, ((na != pa) && (nb != pb)) ? "R5" : "R4");
            end
        end
        // full forward cycle then full reverse cycle (R4)
        do_load(16'h0100);
        move(1'b0, 1'b0, "R4");
        move(1'b1, 1'b0, "R4"); move(1'b1, 1'b1, "R4");
        move(1'b0, 1'b1, "R4"); move(1'b0, 1'b0, "R4");
        check(count_o == 16'h0104, "R4", count_o, 16'h0104);
        move(1'b0, 1'b1, "R4"); move(1'b1, 1'b1, "R4");
        move(1'b1, 1'b0, "R4"); move(1'b0, 1'b0, "R4");
        check(count_o == 16'h0100, "R4", count_o, 16'h0100);

        // R6/R7: wraps in both modes
        do_load(16'hFFFF);
        move(1'b1, 1'b0, "R6");
        @(negedge clk);
        check(!ovf_o && count_o == 0, "R6", ovf_o, 0);
        move(1'b0, 1'b0, "R7");
        @(negedge clk);
        check(!unf_o && count_o == 16'hFFFF, "R7", unf_o, 0);
        quad_mode_i = 1'b0;
        move(cur_a, 1'b1, "R2");
        move(~cur_a, 1'b1, "R6");
        move(cur_a, 1'b0, "R2");
        move(~cur_a, 1'b0, "R7");

        // R8: load lands in the same cycle as a pending step
        evt_dir_i = 1'b1; cur_b = 1'b1;
        repeat (3) @(negedge clk);
        do_load(16'h1234);
        evt_clk_i = ~cur_a; cur_a = ~cur_a;
        @(negedge clk); @(negedge clk);
        load_i = 1'b1; load_val_i = 16'hFFFF;
        @(negedge clk);
        load_i = 1'b0;
        check(count_o == 16'hFFFF && !ovf_o, "R8", count_o, 16'hFFFF);
        repeat (3) @(negedge clk);
        check(count_o == 16'hFFFF && !ovf_o, "R8", count_o, 16'hFFFF);
        exp_cnt = 16'hFFFF;

        // R9: disabled holds, re-enable gives no false step
        enable_i = 1'b0;
        move(~cur_a, cur_b, "R9");
        move(~cur_a, ~cur_b, "R9");
        move(~cur_a, cur_b, "R9");
        enable_i = 1'b1;
        repeat (5) @(negedge clk);
        check(count_o == exp_cnt, "R9", count_o, exp_cnt);
        quad_mode_i = 1'b1;
        enable_i = 1'b0;
        move(~cur_a, cur_b, "R9");
        enable_i = 1'b1;
        repeat (5) @(negedge clk);
        check(count_o == exp_cnt, "R9", count_o, exp_cnt);
        move(cur_a, ~cur_b, "R4");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule